// File: doc/BRIEF.md
# DMA Transfer Controller

This block moves a block of words between one I/O device and memory so the CPU need not handle each word. Software programs four values through a small write-only configuration port: the transfer direction with the release policy, the device address, the first memory address and the number of words. A start bit then launches the transfer. The controller raises a bus request and waits for the CPU's acknowledge. Only while it holds the bus does it drive memory addresses and strobes. Each moved word advances the memory address by one and reduces the remaining count by one.

Two release policies exist. In block mode the controller keeps the bus for consecutive words. In cycle-stealing mode it returns the bus after every word, so CPU cycles can fall between DMA words. In either mode, if the device cannot supply or take a word while words remain, the controller drops its request. It asks again once the device is ready and the CPU has withdrawn the acknowledge. When the count reaches zero it releases the bus and raises an interrupt. The interrupt stays up until software clears it.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: Configuration writes use `cfg_addr` 0 for control (bit 0 start, bit 1 direction with 1 = device to memory and 0 = memory to device, bit 2 policy with 1 = cycle stealing and 0 = block), 1 for device address, 2 for first memory address, 3 for word count and 4 for status. A device address written while idle appears on `dev_addr` one cycle after the write.
- R2: A start write made while idle with a nonzero count asserts `dma_req` from the next cycle on. No memory strobe occurs before `dma_ack` is seen.
- R3: `mem_wr` and `mem_rd` are asserted only while `dma_ack` is high.
- R4: Device to memory: the n-th word accepted from the device (`dev_valid` and `dev_ready` both high) is written to the first address plus n. Memory just below the first address and just above the last address is left unchanged.
- R5: Memory to device: words read from consecutive addresses starting at the first address are handed to the device in address order. Each `mem_rd` or `mem_wr` is a one-cycle pulse, and the two are never high together. Read data is expected the cycle after `mem_rd`.
- R6: In block mode, with a device that is always ready, `dma_req` rises exactly once for the whole transfer.
- R7: In cycle-stealing mode, `dma_req` is dropped after every word, so it rises once per word.
- R8: If the device is not ready while words remain, `dma_req` goes low and `irq` stays low. The transfer resumes when the device is ready again and still moves every word.
- R9: The cycle after the last word, `dma_req` is low and `irq` is high. `irq` stays high until a status write with bit 0 set, and it is low the cycle after that write. A status write with bit 0 clear leaves it high.
- R10: A start with a programmed count of zero raises `irq` on the next cycle, and `dma_req` never rises.
- R11: While `busy` is high, writes to addresses 0 to 3 are ignored. `dev_addr` keeps its value, a second start has no effect, and a new count does not change the length of the running transfer.
- R12: While reset is held, `dma_req`, `mem_wr`, `mem_rd`, `dev_ready`, `dev_out_valid`, `busy` and `irq` are 0, and `dev_addr` and `mem_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | DATA_W | Configuration write data |
| dma_req | output | 1 | Bus request to the CPU |
| dma_ack | input | 1 | Bus grant from the CPU |
| mem_addr | output | ADDR_W | Memory address, driven only while the bus is held |
| mem_wr | output | 1 | One-cycle memory write strobe |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid the cycle after `mem_rd` |
| dev_addr | output | DEV_W | Programmed device address |
| dev_valid | input | 1 | Device offers a word (device to memory) |
| dev_data | input | DATA_W | Word offered by the device |
| dev_ready | output | 1 | Controller takes the offered word |
| dev_out_valid | output | 1 | Controller offers a word to the device (memory to device) |
| dev_out_data | output | DATA_W | Word offered to the device |
| dev_out_ready | input | 1 | Device can take a word |
| busy | output | 1 | A transfer is in progress |
| irq | output | 1 | Completion interrupt, held until cleared |

## Verification
`dma_req` is due one cycle after the start write's clock edge. `irq` is due one cycle after the edge that completes the last word, or one cycle after the start for a zero count. A clear takes effect one cycle after the status write, and a new device address is visible one cycle after it is written. The bench drives inputs and samples outputs on the falling edge, so each of these checks falls on the first falling edge after the edge where the result is due. A handshake model acknowledges one cycle after each request. The bench also counts request rising edges and strobes made without a grant. Where a transfer's length depends on handshakes, the bench waits, within a bound, for `irq` and only then compares memory, delivered words and edge counts.

// File: rtl/dma_xfer_pkg.sv
// Shared constants and types for the DMA transfer controller.
// Assumes a 3-bit configuration address space.
package dma_xfer_pkg;
    localparam logic [2:0] REG_CTRL   = 3'd0;
    localparam logic [2:0] REG_DEV    = 3'd1;
    localparam logic [2:0] REG_BASE   = 3'd2;
    localparam logic [2:0] REG_COUNT  = 3'd3;
    localparam logic [2:0] REG_STATUS = 3'd4;

    localparam int CTRL_START  = 0;
    localparam int CTRL_TO_MEM = 1;
    localparam int CTRL_STEAL  = 2;
    localparam int STATUS_CLR  = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_OWN,
        ST_MWR,
        ST_MRD,
        ST_PUSH,
        ST_WAIT
    } seq_state_t;
endpackage

// File: rtl/dma_cfg_regs.sv
// Configuration registers and completion interrupt of the DMA controller.
// Holds the programmed direction, policy, device address, first address and
// count. Writes to the programming registers are dropped while busy. Emits a
// launch pulse for a nonzero count and sets the interrupt directly for a zero
// count. Assumes ADDR_W, CNT_W and DEV_W do not exceed DATA_W.
module dma_cfg_regs
    import dma_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              last_word,
    output logic              to_mem,
    output logic              steal,
    output logic [DEV_W-1:0]  dev_addr,
    output logic [ADDR_W-1:0] base_addr,
    output logic [CNT_W-1:0]  word_cnt,
    output logic              launch,
    output logic              irq
);
    logic prog_ok;
    logic start_fire;
    logic zero_done;
    logic clr_irq;

    // Decode write qualifiers: programming only when idle, clear at any time.
    always_comb begin
        prog_ok    = wr_en && !busy;
        start_fire = prog_ok && (wr_addr == REG_CTRL) && wr_data[CTRL_START];
        launch     = start_fire && (word_cnt != '0);
        zero_done  = start_fire && (word_cnt == '0);
        clr_irq    = wr_en && (wr_addr == REG_STATUS) && wr_data[STATUS_CLR];
    end

    // Programming registers, updated only while no transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_mem    <= 1'b0;
            steal     <= 1'b0;
            dev_addr  <= '0;
            base_addr <= '0;
            word_cnt  <= '0;
        end else if (prog_ok) begin
            case (wr_addr)
                REG_CTRL: begin
                    to_mem <= wr_data[CTRL_TO_MEM];
                    steal  <= wr_data[CTRL_STEAL];
                end
                REG_DEV:   dev_addr  <= wr_data[DEV_W-1:0];
                REG_BASE:  base_addr <= wr_data[ADDR_W-1:0];
                REG_COUNT: word_cnt  <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end

    // Completion interrupt: setting wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= last_word || zero_done || (irq && !clr_irq);
    end
endmodule

// File: rtl/dma_word_seq.sv
// Bus ownership and word sequencer of the DMA controller.
// Requests the bus, moves one word at a time between device and memory,
// steps the address up and the count down per word, and releases the bus on
// completion, after each word in cycle-stealing mode, or when the device
// stalls. Assumes the CPU keeps dma_ack high while dma_req stays high, and
// that memory returns read data the cycle after mem_rd.
module dma_word_seq
    import dma_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              to_mem,
    input  logic              steal,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [CNT_W-1:0]  word_cnt,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              busy,
    output logic              last_word
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    seq_state_t        state, state_nx;
    logic [ADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]  cur_cnt;
    logic [DATA_W-1:0] word_buf;
    logic              bus_own;
    logic              dev_rdy_any;
    logic              word_done;

    // Status of the current word and of bus ownership.
    always_comb begin
        bus_own     = (state == ST_OWN) || (state == ST_MWR) ||
                      (state == ST_MRD) || (state == ST_PUSH);
        dev_rdy_any = to_mem ? dev_valid : dev_out_ready;
        word_done   = (state == ST_MWR) || ((state == ST_PUSH) && dev_out_ready);
        last_word   = word_done && (cur_cnt == CNT_ONE);
    end

    // Drive the bus, memory and device handshake outputs.
    always_comb begin
        dma_req       = (state == ST_REQ) || bus_own;
        busy          = (state != ST_IDLE);
        mem_addr      = bus_own ? cur_addr : '0;
        mem_wr        = (state == ST_MWR);
        mem_wdata     = (state == ST_MWR) ? word_buf : '0;
        mem_rd        = (state == ST_OWN) && !to_mem && dev_out_ready;
        dev_ready     = (state == ST_OWN) && to_mem;
        dev_out_valid = (state == ST_PUSH);
        dev_out_data  = word_buf;
    end

    // Next-state selection for the word sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE: if (launch) state_nx = ST_REQ;
            ST_REQ:  if (dma_ack) state_nx = ST_OWN;
            ST_OWN: begin
                if (!dev_rdy_any) state_nx = ST_WAIT;
                else if (to_mem)  state_nx = ST_MWR;
                else              state_nx = ST_MRD;
            end
            ST_MRD:  state_nx = ST_PUSH;
            ST_MWR, ST_PUSH: begin
                if (word_done) begin
                    if (last_word)  state_nx = ST_IDLE;
                    else if (steal) state_nx = ST_WAIT;
                    else            state_nx = ST_OWN;
                end
            end
            ST_WAIT: if (dev_rdy_any && !dma_ack) state_nx = ST_REQ;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Address and count registers: load on launch, step after every word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
        end else if ((state == ST_IDLE) && launch) begin
            cur_addr <= base_addr;
            cur_cnt  <= word_cnt;
        end else if (word_done) begin
            cur_addr <= cur_addr + ADDR_ONE;
            cur_cnt  <= cur_cnt - CNT_ONE;
        end
    end

    // Word buffer: captures device data or memory read data.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_buf <= '0;
        else if ((state == ST_OWN) && to_mem && dev_valid)
            word_buf <= dev_data;
        else if (state == ST_MRD)
            word_buf <= mem_rdata;
    end
endmodule

// File: rtl/dma_xfer_ctrl.sv
// Top of the DMA transfer controller: configuration registers plus the word
// sequencer. Assumes a single device channel and a one-word-per-strobe memory.
module dma_xfer_ctrl
    import dma_xfer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int DEV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              dma_req,
    input  logic              dma_ack,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_wr,
    output logic              mem_rd,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DEV_W-1:0]  dev_addr,
    input  logic              dev_valid,
    input  logic [DATA_W-1:0] dev_data,
    output logic              dev_ready,
    output logic              dev_out_valid,
    output logic [DATA_W-1:0] dev_out_data,
    input  logic              dev_out_ready,
    output logic              busy,
    output logic              irq
);
    logic              to_mem;
    logic              steal;
    logic [ADDR_W-1:0] base_addr;
    logic [CNT_W-1:0]  word_cnt;
    logic              launch;
    logic              last_word;

    dma_cfg_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEV_W(DEV_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_wr_en), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
        .busy(busy), .last_word(last_word),
        .to_mem(to_mem), .steal(steal), .dev_addr(dev_addr),
        .base_addr(base_addr), .word_cnt(word_cnt),
        .launch(launch), .irq(irq)
    );

    dma_word_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .to_mem(to_mem), .steal(steal),
        .base_addr(base_addr), .word_cnt(word_cnt),
        .dma_req(dma_req), .dma_ack(dma_ack),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready),
        .busy(busy), .last_word(last_word)
    );
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
// Property checker for the DMA transfer controller, bound to its top.
module dma_xfer_ctrl_chk #(
    parameter int DEV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_en,
    input logic [2:0]       cfg_addr,
    input logic             cfg_clr_bit,
    input logic             dma_req,
    input logic             dma_ack,
    input logic             mem_wr,
    input logic             mem_rd,
    input logic             busy,
    input logic             irq,
    input logic [DEV_W-1:0] dev_addr
);
    logic clr_wr;
    assign clr_wr = cfg_wr_en && (cfg_addr == 3'd4) && cfg_clr_bit;

    AST_STROBE_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> dma_ack); // R3
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_wr, mem_rd})); // R5
    AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> !mem_wr); // R5
    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq); // R9
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && !busy) |=> !irq); // R9
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !dma_req); // R9
    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_wr_en) |=> $stable(dev_addr)); // R11
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk #(.DEV_W(DEV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_clr_bit(cfg_wdata[0]), .dma_req(dma_req), .dma_ack(dma_ack),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .busy(busy), .irq(irq),
    .dev_addr(dev_addr)
);

// File: tb/dma_xfer_ctrl_bench.sv
// Directed bench for the DMA transfer controller with CPU, memory and device models.
module dma_xfer_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int AW = 16;
    localparam int VW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [2:0]    cfg_addr = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          dma_req, dma_ack;
    logic [AW-1:0] mem_addr;
    logic          mem_wr, mem_rd;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [VW-1:0] dev_addr;
    logic          dev_valid, dev_ready, dev_out_valid;
    logic [DW-1:0] dev_data, dev_out_data;
    logic          dev_out_ready;
    logic          busy, irq;

    int n_chk = 0;
    int n_bad = 0;

    // Models' state
    logic [DW-1:0] mem [0:63];
    logic          src_en = 1'b0;
    int            src_idx = 0;
    int            src_n = 0;
    logic [DW-1:0] src_seed = '0;
    logic          snk_en = 1'b0;
    logic [DW-1:0] snk_buf [0:15];
    int            snk_n = 0;
    int            req_rises = 0;
    int            bad_strobes = 0;
    logic          req_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_xfer_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(16), .DEV_W(VW)) u_dma_xfer_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dma_req(dma_req), .dma_ack(dma_ack),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_rd(mem_rd),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_addr(dev_addr),
        .dev_valid(dev_valid), .dev_data(dev_data), .dev_ready(dev_ready),
        .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
        .dev_out_ready(dev_out_ready), .busy(busy), .irq(irq)
    );

    assign dev_valid     = src_en && (src_idx < src_n);
    assign dev_data      = src_seed + DW'(src_idx);
    assign dev_out_ready = snk_en;

    // CPU grants one cycle after the request and withdraws one cycle after release
    always @(posedge clk) begin
        if (!rst_n) dma_ack <= 1'b0;
        else        dma_ack <= dma_req;
    end

    // Memory, device and bus monitors
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[5:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[5:0]];
        if (dev_valid && dev_ready) src_idx <= src_idx + 1;
        if (dev_out_valid && dev_out_ready && snk_n < 16) begin
            snk_buf[snk_n] <= dev_out_data;
            snk_n <= snk_n + 1;
        end
        req_q <= dma_req;
        if (rst_n && dma_req && !req_q) req_rises <= req_rises + 1;
        if (rst_n && (mem_wr || mem_rd) && !dma_ack) bad_strobes <= bad_strobes + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [DW-1:0] d);
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0; cfg_wdata = '0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 2000) begin @(negedge clk); n++; end
        chk(irq == 1'b1, req, int'(irq), 1);
    endtask

    task automatic clear_irq();
        cfg_write(3'd4, 16'h0001);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!dma_req && !mem_wr && !mem_rd && !busy && !irq, "R12 strobes",
            int'({dma_req, mem_wr, mem_rd, busy, irq}), 0);
        chk(!dev_ready && !dev_out_valid, "R12 device", int'({dev_ready, dev_out_valid}), 0);
        chk(dev_addr == '0 && mem_addr == '0, "R12 addresses", int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Block write, device always ready: one request, consecutive addresses
    task automatic t_block_write();
        src_idx = 0; src_n = 5; src_seed = 16'hB000; src_en = 1'b1;
        cfg_write(3'd2, 16'd2);
        cfg_write(3'd3, 16'd5);
        req_rises = 0;
        cfg_write(3'd0, 16'b011);
        chk(dma_req == 1'b1, "R2 request after start", int'(dma_req), 1);
        wait_irq("R9 block irq");
        chk(dma_req == 1'b0 && busy == 1'b0, "R9 bus released", int'({dma_req, busy}), 0);
        for (int i = 0; i < 5; i++)
            chk(mem[2+i] == 16'hB000 + 16'(i), "R4 word", int'(mem[2+i]), 16'hB000 + i);
        chk(mem[1] == 16'h1001, "R4 below untouched", int'(mem[1]), 16'h1001);
        chk(mem[7] == 16'h1007, "R4 above untouched", int'(mem[7]), 16'h1007);
        chk(req_rises == 1, "R6 single request", req_rises, 1);
        cfg_write(3'd4, 16'h0000);
        chk(irq == 1'b1, "R9 clear bit zero keeps irq", int'(irq), 1);
        clear_irq();
        chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
        src_en = 1'b0;
    endtask

    // Cycle-stealing read: words delivered in order, one request per word
    task automatic t_steal_read();
        snk_n = 0; snk_en = 1'b1;
        cfg_write(3'd2, 16'd8);
        cfg_write(3'd3, 16'd4);
        req_rises = 0;
        cfg_write(3'd0, 16'b101);
        wait_irq("R9 steal irq");
        chk(snk_n == 4, "R5 word count", snk_n, 4);
        for (int i = 0; i < 4; i++)
            chk(snk_buf[i] == 16'h1008 + 16'(i), "R5 order", int'(snk_buf[i]), 16'h1008 + i);
        chk(req_rises == 4, "R7 request per word", req_rises, 4);
        clear_irq();
        snk_en = 1'b0;
    endtask

    // Device stalls mid-block: request dropped, then resumed
    task automatic t_stall_write();
        int n = 0;
        src_idx = 0; src_n = 6; src_seed = 16'hC000; src_en = 1'b1;
        cfg_write(3'd2, 16'd20);
        cfg_write(3'd3, 16'd6);
        req_rises = 0;
        cfg_write(3'd0, 16'b011);
        while (src_idx < 2 && n < 200) begin @(negedge clk); n++; end
        src_en = 1'b0;
        repeat (4) @(negedge clk);
        chk(dma_req == 1'b0, "R8 request dropped", int'(dma_req), 0);
        chk(irq == 1'b0 && busy == 1'b1, "R8 no irq mid-transfer", int'({irq, busy}), 1);
        src_en = 1'b1;
        wait_irq("R8 resumed to end");
        for (int i = 0; i < 6; i++)
            chk(mem[20+i] == 16'hC000 + 16'(i), "R8 word", int'(mem[20+i]), 16'hC000 + i);
        chk(req_rises == 2, "R8 re-request", req_rises, 2);
        clear_irq();
        src_en = 1'b0;
    endtask

    task automatic t_zero_count();
        cfg_write(3'd3, 16'd0);
        req_rises = 0;
        cfg_write(3'd0, 16'b011);
        chk(irq == 1'b1, "R10 irq next cycle", int'(irq), 1);
        repeat (5) @(negedge clk);
        chk(req_rises == 0 && busy == 1'b0, "R10 no request", req_rises, 0);
        clear_irq();
    endtask

    // Writes while busy are dropped; programming works again once idle
    task automatic t_busy_ignore();
        src_idx = 0; src_n = 10; src_seed = 16'hD000; src_en = 1'b0;
        cfg_write(3'd1, 16'h0021);
        chk(dev_addr == 8'h21, "R1 device address", int'(dev_addr), 16'h21);
        cfg_write(3'd2, 16'd40);
        cfg_write(3'd3, 16'd6);
        cfg_write(3'd0, 16'b011);
        repeat (3) @(negedge clk);
        chk(busy == 1'b1, "R11 busy", int'(busy), 1);
        cfg_write(3'd1, 16'h0055);
        cfg_write(3'd3, 16'd1);
        cfg_write(3'd0, 16'b101);
        chk(dev_addr == 8'h21, "R11 device address kept", int'(dev_addr), 16'h21);
        src_en = 1'b1;
        wait_irq("R11 irq");
        chk(src_idx == 6, "R11 length unchanged", src_idx, 6);
        chk(mem[46] == 16'h102E, "R11 no extra word", int'(mem[46]), 16'h102E);
        chk(mem[45] == 16'hD005, "R11 last word", int'(mem[45]), 16'hD005);
        clear_irq();
        src_en = 1'b0;
        cfg_write(3'd1, 16'h0033);
        chk(dev_addr == 8'h33, "R1 write after idle", int'(dev_addr), 16'h33);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h1000 + 16'(i);
        mem_rdata = '0;
        t_reset();
        t_block_write();
        t_steal_read();
        t_stall_write();
        t_zero_count();
        t_busy_ignore();
        chk(bad_strobes == 0, "R3 strobes only with grant", bad_strobes, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule